// File: doc/BRIEF.md
# Gate-Timed NAND Ripple Adder

This block adds two 32-bit operands and a carry-in using a network built only from two-input NAND gates, nine per bit position. Every gate output is held in its own flip-flop that updates on each clock edge, so one clock cycle stands for one gate delay. Results therefore settle over time the way they would in a real gate network, and the block reports the answer only once the deepest path has had time to settle.

A request is a one-cycle `start` while `ready` is high. The block then captures the operands and runs a compute phase. The carry moves two gate delays per bit, while each bit's sum needs six delays from its operands. The total latency is 2(W-1)+6 cycles, which is 68 for W = 32. At that point `done` pulses and the result is placed in output registers.

A clear phase of two cycles follows, during which every gate is driven to logic 1, its idle value. The next request can then be issued. Bits are grouped in a hierarchy of 4-bit groups inside 16-bit sections, and the carry ripples straight through every group and section boundary.

Top module: `nand_ripple_adder`

## Requirements
- R1: When `done` is high, {`carry_out`, `sum`} equals the 33-bit value A + B + carry_in of the operands captured by the accepting edge.
- R2: `done` is high for exactly one cycle. It goes high right after the 68th rising edge that follows the accepting edge (2(W-1)+6 edges), and never earlier.
- R3: `ready` goes low right after the accepting edge and stays low while `done` is high. It goes high again right after the 69th edge, so a `start` on the 70th edge is accepted and requests can follow each other every 70 cycles.
- R4: A `start` seen while `ready` is low is ignored. The running addition completes with its own operands, and no extra `done` appears.
- R5: `op_a`, `op_b` and `carry_in` are sampled only on the accepting edge. Changes to them afterwards do not affect the result.
- R6: `sum` and `carry_out` change only on the edge that raises `done`. They keep their value through the clear phase and through idle time until the next result.
- R7: A synchronous active-high `rst` sets `ready` to 1 and sets `done`, `sum` and `carry_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one period equals one gate delay |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken only while ready is high |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| ready | output | 1 | High when a request would be accepted on the next edge |
| done | output | 1 | One-cycle pulse when the result is registered |
| sum | output | 32 | Registered sum bits |
| carry_out | output | 1 | Registered carry out of the top bit |

## Verification
The bound checker watches several properties on every cycle. It checks the arithmetic result against the captured operands and the exact edge count from acceptance to `done` and to the return of `ready`. It also checks that `done` lasts one cycle, that operands stay frozen while busy, and that the outputs change only when `done` rises.

Other behaviours can only be shown by the bench's scenarios. These are the full-length carry chains (all ones plus one, all ones plus all ones with carry-in), the scrambling of the inputs after acceptance, strobes issued while busy, back-to-back requests exactly 70 cycles apart, and results held over idle gaps.

// File: rtl/nand_add_pkg.sv
`timescale 1ns/1ps
package nand_add_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CALC  = 2'd1,
        PH_CLEAR = 2'd2
    } phase_e;

    // The nine gate outputs of one full-adder cell
    typedef struct packed {
        logic g1; // nand(a, b)
        logic g2; // nand(a, g1)
        logic g3; // nand(b, g1)
        logic g4; // a xor b
        logic g5; // nand(g4, ci)
        logic g6; // nand(g4, g5)
        logic g7; // nand(ci, g5)
        logic g8; // sum
        logic g9; // carry out
    } fa_gate_t;

    localparam int unsigned CLEAR_CYCLES = 2;

    function automatic logic nand2(input logic x, input logic y);
        return ~(x & y);
    endfunction

    function automatic int unsigned settle_cycles(input int unsigned w);
        return 2 * (w - 1) + 6;
    endfunction

    // Next state of every gate: each gate reads the registered outputs of its fan-in
    function automatic fa_gate_t fa_next(input fa_gate_t q, input logic a,
                                         input logic b, input logic ci);
        fa_gate_t d;
        d.g1 = nand2(a, b);
        d.g2 = nand2(a, q.g1);
        d.g3 = nand2(b, q.g1);
        d.g4 = nand2(q.g2, q.g3);
        d.g5 = nand2(q.g4, ci);
        d.g6 = nand2(q.g4, q.g5);
        d.g7 = nand2(ci, q.g5);
        d.g8 = nand2(q.g6, q.g7);
        d.g9 = nand2(q.g1, q.g5);
        return d;
    endfunction

endpackage

// File: rtl/nand_fa_cell.sv
`timescale 1ns/1ps
module nand_fa_cell
    import nand_add_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic sum_d,
    output logic co
);
    fa_gate_t q;
    fa_gate_t d;

    always_comb d = fa_next(q, a, b, ci);

    // Outside the compute phase every gate rests at 1
    always_ff @(posedge clk) begin
        if (rst || !run) q <= '1;
        else             q <= d;
    end

    assign sum_d = d.g8;
    assign co    = q.g9;
endmodule

// File: rtl/nand_add_grp.sv
`timescale 1ns/1ps
module nand_add_grp #(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [LANES-1:0] a,
    input  logic [LANES-1:0] b,
    input  logic             ci,
    output logic [LANES-1:0] sum_d,
    output logic             co
);
    logic [LANES:0] chain;
    assign chain[0] = ci;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        nand_fa_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .run   (run),
            .a     (a[i]),
            .b     (b[i]),
            .ci    (chain[i]),
            .sum_d (sum_d[i]),
            .co    (chain[i+1])
        );
    end

    assign co = chain[LANES];
endmodule

// File: rtl/nand_add_sect.sv
`timescale 1ns/1ps
module nand_add_sect #(
    parameter int unsigned FA_PER_GRP   = 4,
    parameter int unsigned GRP_PER_SECT = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                run,
    input  logic [FA_PER_GRP*GRP_PER_SECT-1:0]  a,
    input  logic [FA_PER_GRP*GRP_PER_SECT-1:0]  b,
    input  logic                                ci,
    output logic [FA_PER_GRP*GRP_PER_SECT-1:0]  sum_d,
    output logic                                co
);
    logic [GRP_PER_SECT:0] chain;
    assign chain[0] = ci;

    for (genvar g = 0; g < GRP_PER_SECT; g++) begin : g_grp
        nand_add_grp #(.LANES(FA_PER_GRP)) u_grp (
            .clk   (clk),
            .rst   (rst),
            .run   (run),
            .a     (a[g*FA_PER_GRP +: FA_PER_GRP]),
            .b     (b[g*FA_PER_GRP +: FA_PER_GRP]),
            .ci    (chain[g]),
            .sum_d (sum_d[g*FA_PER_GRP +: FA_PER_GRP]),
            .co    (chain[g+1])
        );
    end

    assign co = chain[GRP_PER_SECT];
endmodule

// File: rtl/nand_ripple_adder.sv
`timescale 1ns/1ps
module nand_ripple_adder
    import nand_add_pkg::*;
#(
    parameter int unsigned WIDTH        = 32,
    parameter int unsigned FA_PER_GRP   = 4,
    parameter int unsigned GRP_PER_SECT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic             ready,
    output logic             done,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int unsigned SECT_W = FA_PER_GRP * GRP_PER_SECT;
    localparam int unsigned N_SECT = WIDTH / SECT_W;
    localparam int unsigned LAT    = settle_cycles(WIDTH);
    localparam int unsigned LAST   = LAT + CLEAR_CYCLES;
    localparam int unsigned CW     = $clog2(LAST + 1);

    phase_e         phase;
    logic [CW-1:0]  cnt;
    logic [WIDTH-1:0] opa_q, opb_q, sum_q;
    logic           ci_q, co_q, done_q;
    logic           run;
    logic [WIDTH-1:0] sum_d;
    logic [N_SECT:0]  sect_c;

    assign run   = (phase == PH_CALC);
    assign ready = (phase == PH_IDLE) ||
                   (phase == PH_CLEAR && cnt == CW'(LAST));

    assign sect_c[0] = ci_q;

    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
        nand_add_sect #(
            .FA_PER_GRP   (FA_PER_GRP),
            .GRP_PER_SECT (GRP_PER_SECT)
        ) u_sect (
            .clk   (clk),
            .rst   (rst),
            .run   (run),
            .a     (opa_q[s*SECT_W +: SECT_W]),
            .b     (opb_q[s*SECT_W +: SECT_W]),
            .ci    (sect_c[s]),
            .sum_d (sum_d[s*SECT_W +: SECT_W]),
            .co    (sect_c[s+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            opa_q  <= '0;
            opb_q  <= '0;
            ci_q   <= 1'b0;
            sum_q  <= '0;
            co_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        opa_q <= op_a;
                        opb_q <= op_b;
                        ci_q  <= carry_in;
                        phase <= PH_CALC;
                        cnt   <= CW'(1);
                    end
                end
                PH_CALC: begin
                    cnt <= cnt + CW'(1);
                    if (cnt == CW'(LAT)) begin
                        sum_q  <= sum_d;
                        co_q   <= sect_c[N_SECT];
                        done_q <= 1'b1;
                        phase  <= PH_CLEAR;
                    end
                end
                PH_CLEAR: begin
                    if (cnt == CW'(LAST)) begin
                        if (start) begin
                            opa_q <= op_a;
                            opb_q <= op_b;
                            ci_q  <= carry_in;
                            phase <= PH_CALC;
                            cnt   <= CW'(1);
                        end else begin
                            phase <= PH_IDLE;
                            cnt   <= '0;
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign done      = done_q;
    assign sum       = sum_q;
    assign carry_out = co_q;
endmodule

// File: rtl/nand_ripple_adder_chk.sv
`timescale 1ns/1ps
module nand_ripple_adder_chk
    import nand_add_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             ready,
    input logic             done,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             ci
);
    localparam int unsigned LAT = settle_cycles(WIDTH);

    logic [15:0] since;
    logic        active;

    always_ff @(posedge clk) begin
        if (rst) begin
            since  <= '0;
            active <= 1'b0;
        end else if (start && ready) begin
            since  <= '0;
            active <= 1'b1;
        end else if (active && since != 16'hFFFF) begin
            since <= since + 16'd1;
        end
    end

    AST_RESULT_MATCHES: assert property (@(posedge clk) disable iff (rst)
        done |-> ({carry_out, sum} == ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, ci}))); // R1
    AST_DONE_AT_SETTLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (active && since == 16'(LAT))); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2
    AST_READY_RETURN: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (since == 16'(LAT + 1))); // R3
    AST_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !ready); // R3
    AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ready |=> ($stable(opa) && $stable(opb) && $stable(ci))); // R4
    AST_OUTPUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !$stable({carry_out, sum}) |-> done); // R6
endmodule

bind nand_ripple_adder nand_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ready     (ready),
    .done      (done),
    .sum       (sum),
    .carry_out (carry_out),
    .opa       (opa_q),
    .opb       (opb_q),
    .ci        (ci_q)
);

// File: tb/nand_ripple_adder_bench.sv
`timescale 1ns/1ps
module nand_ripple_adder_bench;
    localparam int W   = 32;
    localparam int LAT = 2 * (W - 1) + 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic         ready, done, carry_out;
    logic [W-1:0] sum;

    int checks = 0;
    int fails  = 0;
    logic [W:0] last_res = '0;

    always #2.5 clk = ~clk;

    nand_ripple_adder u_nand_ripple_adder (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .ready     (ready),
        .done      (done),
        .sum       (sum),
        .carry_out (carry_out)
    );

    task automatic check(input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // One request; returns after the edge that should raise ready again
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic c, input bit poke);
        logic [W:0] exp;
        bit early, rdy_bad;
        exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        @(negedge clk);
        check(ready === 1'b1, "R3 ready before request", 64'(ready), 64'd1);
        start = 1'b1; op_a = a; op_b = b; carry_in = c;
        @(posedge clk); #1;
        check(ready === 1'b0, "R3 ready low after accept", 64'(ready), 64'd0);
        early = 0; rdy_bad = 0;
        for (int k = 1; k <= LAT + 1; k++) begin
            @(negedge clk);
            start    = poke && (k == 20);   // R4 strobe while busy
            op_a     = $urandom;            // R5 scramble inputs
            op_b     = $urandom;
            carry_in = 1'($urandom);
            @(posedge clk); #1;
            if (k < LAT) begin
                if (done !== 1'b0) early = 1;
                if (ready !== 1'b0) rdy_bad = 1;
            end else if (k == LAT) begin
                check(done === 1'b1, "R2 done at settle edge", 64'(done), 64'd1);
                check(!early, "R2 no early done", 64'(early), 64'd0);
                check(!rdy_bad && ready === 1'b0, "R3 ready low while busy", 64'(ready), 64'd0);
                check({carry_out, sum} === exp, "R1 R4 R5 result", 64'({carry_out, sum}), 64'(exp));
            end else begin
                check(done === 1'b0, "R2 done single cycle", 64'(done), 64'd0);
                check({carry_out, sum} === exp, "R6 held in clear", 64'({carry_out, sum}), 64'(exp));
                check(ready === 1'b1, "R3 ready back", 64'(ready), 64'd1);
            end
        end
        start = 1'b0;
        last_res = exp;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(ready === 1'b1, "R7 reset ready", 64'(ready), 64'd1);
        check(done === 1'b0, "R7 reset done", 64'(done), 64'd0);
        check({carry_out, sum} === '0, "R7 reset result", 64'({carry_out, sum}), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // directed carry corners, back to back
        run_op('1, 32'd1, 1'b0, 0);
        run_op('0, '0, 1'b0, 0);
        run_op('1, '1, 1'b1, 0);
        run_op('1, '0, 1'b1, 1);
        run_op(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 0);
        run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1);
        run_op(32'h0000_FFFF, 32'h0000_0001, 1'b0, 0);

        // walking single-bit operand plus all-ones
        for (int i = 0; i < W; i += 4)
            run_op(32'd1 << i, '1, 1'(i[2]), i[3]);

        // idle gap, then verify result held (R6)
        repeat (10) @(posedge clk);
        #1;
        check({carry_out, sum} === last_res, "R6 held over idle", 64'({carry_out, sum}), 64'(last_res));

        for (int n = 0; n < 16; n++)
            run_op($urandom, $urandom, 1'($urandom), n[0]);

        summary();
    end
endmodule